// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Coherent Byte Buffering

This block is one PWM channel whose counter ramps up from zero to a top value and back down again, so the output pulse sits symmetrically around count zero. Software loads the 16-bit compare value and the 16-bit modulus one byte at a time over an 8-bit write port. While the counter runs, each pair of bytes is collected in a buffer. The pair moves into the working register only at the counter peak, and only once both halves have arrived. A duty or period change therefore never splits a period.

The counter has two states. In `CT_UP` it increments and moves to `CT_DOWN` on the step that lands on the top value. In `CT_DOWN` it decrements and moves back to `CT_UP` on the step that lands on zero. The top value is the modulus, or all ones when the modulus is zero. Each of the two buffered registers has its own pairing machine with four states: `PB_EMPTY`, `PB_HI_ONLY`, `PB_LO_ONLY` and `PB_BOTH`. A high-byte or low-byte write records that byte, and the machine reaches `PB_BOTH` once both bytes are present. A peak event while in `PB_BOTH` moves the buffer into the working register and returns the machine to `PB_EMPTY`. While the counter is stopped, a write updates the working byte at once and also returns the machine to `PB_EMPTY`. A modulus write made while the debug input is high returns the modulus machine to `PB_EMPTY`. A write that arrives in the same cycle as a transfer begins a new pair.

Top module: `cpwm_center_chan`

## Requirements
- R1: After reset the counter reads 0 and the output is low. Both working registers and both buffers are 0, and both pairing machines are in `PB_EMPTY`.
- R2: With `clk_sel` non-zero, the counter runs 0 → top → 0 in steps of one, so one period lasts 2×top clocks. Top is the modulus, or 0xFFFF when the modulus is 0. With `clk_sel` = 00 the counter holds its value.
- R3: With `clk_sel` = 00, a byte write goes straight into the working register and is visible in the next cycle. The high byte is bits 15:8 and the low byte is bits 7:0. The write also discards any pending pair for that register.
- R4: With the counter running, a compare write is held in the buffer. The pair reaches the working register only after both bytes have been written, in either order.
- R5: The transfer happens on the step from top−1 to top. A pair that lacks one byte never transfers.
- R6: With the modulus at 0, the transfer happens on the step from 0xFFFE to 0xFFFF.
- R7: The output is high whenever the counter is below the compare value. A compare value at or above top keeps the output high for the whole period.
- R8: A compare value of top−1 holds the output low for the three counts top−1, top, top−1 around the peak.
- R9: After the compare value changes from 0 to a non-zero value, the output stays low for the rest of the current period. The new duty starts at the next peak.
- R10: After the compare value changes from non-zero to 0, the current period finishes with the old duty. The output is low from the next peak onward.
- R11: A modulus byte write made while `dbg_mode` is high is discarded and returns the modulus pairing machine to `PB_EMPTY`.
- R12: A buffered modulus pair transfers at the same peak step as the compare value, and the counter then turns at the new top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | Counter enable; 00 stops the counter |
| dbg_mode | input | 1 | Debug mode; modulus writes clear the modulus pairing |
| wr_data | input | 8 | Write data byte |
| wr_cv_hi | input | 1 | Write strobe, compare high byte |
| wr_cv_lo | input | 1 | Write strobe, compare low byte |
| wr_mod_hi | input | 1 | Write strobe, modulus high byte |
| wr_mod_lo | input | 1 | Write strobe, modulus low byte |
| cnt_out | output | 16 | Counter value |
| pwm_out | output | 1 | High-true PWM output |

## Verification
A wrong pairing state shows up at the ports as a duty or period change that lands one whole period early or late. Such an error can only be seen at the next peak, which is up to 2×top clocks after the faulty write. A wrong counter direction or top value shows up on `cnt_out` in the very next cycle. A wrong compare comparison shows up on `pwm_out` in the same cycle as the count that crosses it. The bench therefore compares both outputs with a behavioural model on every clock, and also counts high cycles over whole periods.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    parameter int unsigned CPWM_BYTE_W = 8;

    typedef enum logic [1:0] {
        PB_EMPTY   = 2'd0,
        PB_HI_ONLY = 2'd1,
        PB_LO_ONLY = 2'd2,
        PB_BOTH    = 2'd3
    } pair_st_t;

    typedef enum logic {
        CT_UP   = 1'b0,
        CT_DOWN = 1'b1
    } ctr_dir_t;

endpackage

// File: rtl/cpwm_pair_buf.sv
module cpwm_pair_buf
    import cpwm_pkg::*;
#(
    parameter int unsigned BYTE_W = CPWM_BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic                  clr_pair,
    input  logic                  load,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [2*BYTE_W-1:0]   act_val
);
    localparam int unsigned VAL_W = 2 * BYTE_W;

    pair_st_t          st_q;
    pair_st_t          st_d;
    pair_st_t          base_st;
    logic              take;
    logic              got_hi;
    logic              got_lo;
    logic [VAL_W-1:0]  buf_q;
    logic [VAL_W-1:0]  act_q;

    // a complete pair is moved only on the peak step
    assign take = load && (st_q == PB_BOTH);

    // next pairing state
    always_comb begin
        base_st = take ? PB_EMPTY : st_q;
        got_hi  = wr_hi || (base_st == PB_HI_ONLY) || (base_st == PB_BOTH);
        got_lo  = wr_lo || (base_st == PB_LO_ONLY) || (base_st == PB_BOTH);
        st_d    = base_st;
        if (clr_pair) begin
            st_d = PB_EMPTY;
        end else if (!run) begin
            if (wr_hi || wr_lo) begin
                st_d = PB_EMPTY;
            end
        end else begin
            unique case ({got_hi, got_lo})
                2'b00:   st_d = PB_EMPTY;
                2'b10:   st_d = PB_HI_ONLY;
                2'b01:   st_d = PB_LO_ONLY;
                default: st_d = PB_BOTH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PB_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // buffer and working value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (take) begin
                act_q <= buf_q;
            end else if (!run && !clr_pair) begin
                if (wr_hi) act_q[VAL_W-1:BYTE_W] <= wr_data;
                if (wr_lo) act_q[BYTE_W-1:0]     <= wr_data;
            end
            if (run && !clr_pair) begin
                if (wr_hi) buf_q[VAL_W-1:BYTE_W] <= wr_data;
                if (wr_lo) buf_q[BYTE_W-1:0]     <= wr_data;
            end
        end
    end

    assign act_val = act_q;

    AST_ACT_HOLDS_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !take) |=> $stable(act_q)); // R4

    AST_CLR_EMPTIES_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pair && !take) |=> (st_q == PB_EMPTY && $stable(act_q))); // R11

    AST_DIRECT_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wr_lo && !clr_pair) |=> (act_q[BYTE_W-1:0] == $past(wr_data))); // R3

endmodule

// File: rtl/cpwm_updown_ctr.sv
module cpwm_updown_ctr
    import cpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 2 * CPWM_BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic             peak
);
    ctr_dir_t         dir_q;
    ctr_dir_t         dir_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // next count and direction
    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        if (run) begin
            unique case (dir_q)
                CT_UP: begin
                    if (cnt_q >= top) begin
                        cnt_d = cnt_q - 1'b1;
                        dir_d = CT_DOWN;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == top - 1'b1) dir_d = CT_DOWN;
                    end
                end
                CT_DOWN: begin
                    if (cnt_q == '0) begin
                        cnt_d = cnt_q + 1'b1;
                        dir_d = CT_UP;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                        if (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) dir_d = CT_UP;
                    end
                end
                default: begin
                    cnt_d = cnt_q;
                    dir_d = CT_UP;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= CT_UP;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs: peak marks the step top-1 -> top
    always_comb begin
        cnt  = cnt_q;
        peak = run && (dir_q == CT_UP) && (cnt_q == top - 1'b1);
    end

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q)); // R2

    AST_PEAK_LANDS_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        peak |=> (cnt_q == $past(top))); // R5

endmodule

// File: rtl/cpwm_center_chan.sv
module cpwm_center_chan
    import cpwm_pkg::*;
#(
    parameter int unsigned BYTE_W = CPWM_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic              dbg_mode,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_cv_hi,
    input  logic              wr_cv_lo,
    input  logic              wr_mod_hi,
    input  logic              wr_mod_lo,
    output logic [2*BYTE_W-1:0] cnt_out,
    output logic              pwm_out
);
    localparam int unsigned VAL_W  = 2 * BYTE_W;
    localparam int unsigned N_REG  = 2;
    localparam int unsigned IDX_CV = 0;
    localparam int unsigned IDX_MD = 1;

    logic              run;
    logic              peak;
    logic              mod_wr_any;
    logic [VAL_W-1:0]  cnt;
    logic [VAL_W-1:0]  top_val;
    logic [VAL_W-1:0]  cv_val;
    logic [VAL_W-1:0]  mod_val;
    logic              hi_v  [N_REG];
    logic              lo_v  [N_REG];
    logic              clr_v [N_REG];
    logic [VAL_W-1:0]  val_v [N_REG];

    assign run        = |clk_sel;
    assign mod_wr_any = wr_mod_hi | wr_mod_lo;

    // write routing; debug-mode modulus writes only clear the pairing
    assign hi_v[IDX_CV]  = wr_cv_hi;
    assign lo_v[IDX_CV]  = wr_cv_lo;
    assign clr_v[IDX_CV] = 1'b0;
    assign hi_v[IDX_MD]  = wr_mod_hi & ~dbg_mode;
    assign lo_v[IDX_MD]  = wr_mod_lo & ~dbg_mode;
    assign clr_v[IDX_MD] = mod_wr_any & dbg_mode;

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        cpwm_pair_buf #(.BYTE_W(BYTE_W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .wr_hi    (hi_v[g]),
            .wr_lo    (lo_v[g]),
            .clr_pair (clr_v[g]),
            .load     (peak),
            .wr_data  (wr_data),
            .act_val  (val_v[g])
        );
    end

    assign cv_val  = val_v[IDX_CV];
    assign mod_val = val_v[IDX_MD];
    assign top_val = (mod_val == '0) ? {VAL_W{1'b1}} : mod_val;

    cpwm_updown_ctr #(.CNT_W(VAL_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .top   (top_val),
        .cnt   (cnt),
        .peak  (peak)
    );

    // outputs
    always_comb begin
        cnt_out = cnt;
        pwm_out = (cv_val >= top_val) || (cnt < cv_val);
    end

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_val == '0) |-> !pwm_out); // R10

    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_val != '0 && cv_val == mod_val) |-> pwm_out); // R7

    AST_NEAR_FULL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_val > 1 && cv_val == mod_val - 1'b1 && cnt == mod_val) |-> !pwm_out); // R8

endmodule

// File: tb/cpwm_center_chan_tb_top.sv
module cpwm_center_chan_tb_top;
    localparam int FULL = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_sel = 2'b00;
    logic        dbg_mode = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_cv_hi = 1'b0;
    logic        wr_cv_lo = 1'b0;
    logic        wr_mod_hi = 1'b0;
    logic        wr_mod_lo = 1'b0;
    logic [15:0] cnt_out;
    logic        pwm_out;

    always #5 clk = ~clk;

    cpwm_center_chan dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .dbg_mode  (dbg_mode),
        .wr_data   (wr_data),
        .wr_cv_hi  (wr_cv_hi),
        .wr_cv_lo  (wr_cv_lo),
        .wr_mod_hi (wr_mod_hi),
        .wr_mod_lo (wr_mod_lo),
        .cnt_out   (cnt_out),
        .pwm_out   (pwm_out)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    live = 0;
    bit    done = 0;

    // behavioural reference model
    int m_cnt, m_cv, m_mod, m_cvb, m_modb, m_tp;
    bit m_up, cv_h, cv_l, md_h, md_l, m_run, m_pk, cv_ld, md_ld;

    function automatic int top_of(int md);
        return (md == 0) ? FULL : md;
    endfunction

    function automatic int model_pwm();
        int tp;
        tp = top_of(m_mod);
        return ((m_cv >= tp) || (m_cnt < m_cv)) ? 1 : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_cv = 0; m_mod = 0; m_cvb = 0; m_modb = 0; m_up = 1;
            cv_h = 0; cv_l = 0; md_h = 0; md_l = 0;
        end else begin
            m_tp  = top_of(m_mod);
            m_run = (clk_sel != 2'b00);
            m_pk  = m_run && m_up && (m_cnt == m_tp - 1);
            cv_ld = m_pk && cv_h && cv_l;
            md_ld = m_pk && md_h && md_l;
            if (m_run) begin
                if (m_up) begin
                    if (m_cnt >= m_tp) begin m_cnt = m_cnt - 1; m_up = 0; end
                    else begin m_cnt = m_cnt + 1; if (m_cnt == m_tp) m_up = 0; end
                end else begin
                    if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
                    else begin m_cnt = m_cnt - 1; if (m_cnt == 0) m_up = 1; end
                end
            end
            if (cv_ld) begin m_cv = m_cvb; cv_h = 0; cv_l = 0; end
            if (!m_run) begin
                if (wr_cv_hi) m_cv = (m_cv & 255) | (int'(wr_data) << 8);
                if (wr_cv_lo) m_cv = (m_cv & 65280) | int'(wr_data);
                if (wr_cv_hi || wr_cv_lo) begin cv_h = 0; cv_l = 0; end
            end else begin
                if (wr_cv_hi) begin m_cvb = (m_cvb & 255) | (int'(wr_data) << 8); cv_h = 1; end
                if (wr_cv_lo) begin m_cvb = (m_cvb & 65280) | int'(wr_data); cv_l = 1; end
            end
            if (md_ld) begin m_mod = m_modb; md_h = 0; md_l = 0; end
            if (dbg_mode && (wr_mod_hi || wr_mod_lo)) begin
                md_h = 0; md_l = 0;
            end else if (!m_run) begin
                if (wr_mod_hi) m_mod = (m_mod & 255) | (int'(wr_data) << 8);
                if (wr_mod_lo) m_mod = (m_mod & 65280) | int'(wr_data);
                if (wr_mod_hi || wr_mod_lo) begin md_h = 0; md_l = 0; end
            end else begin
                if (wr_mod_hi) begin m_modb = (m_modb & 255) | (int'(wr_data) << 8); md_h = 1; end
                if (wr_mod_lo) begin m_modb = (m_modb & 65280) | int'(wr_data); md_l = 1; end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (live && !done) begin
            chk(tag, int'(cnt_out), m_cnt);
            chk(tag, int'(pwm_out), model_pwm());
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // which: 0 cv hi, 1 cv lo, 2 mod hi, 3 mod lo
    task automatic wr(input int which, input int data);
        @(negedge clk);
        wr_data   = data[7:0];
        wr_cv_hi  = (which == 0);
        wr_cv_lo  = (which == 1);
        wr_mod_hi = (which == 2);
        wr_mod_lo = (which == 3);
        @(negedge clk);
        wr_cv_hi = 0; wr_cv_lo = 0; wr_mod_hi = 0; wr_mod_lo = 0;
    endtask

    task automatic wait_cnt(input int v);
        while (int'(cnt_out) != v) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
    endtask

    task automatic max_cnt(input int n, output int mx);
        mx = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (int'(cnt_out) > mx) mx = int'(cnt_out);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int v;
        int held;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(cnt_out), 0);
        chk("R1", int'(pwm_out), 0);
        live = 1;

        // stopped: direct writes, mod=10, cv=4
        tag = "R3";
        wr(2, 0); wr(3, 10); wr(0, 0); wr(1, 4);
        chk("R3", int'(pwm_out), 1);
        held = int'(cnt_out);
        cyc(5);
        chk("R2", int'(cnt_out), held);

        // run: 0 -> 10 -> 0
        tag = "R2";
        clk_sel = 2'b01;
        max_cnt(40, v);
        chk("R2", v, 10);
        wait_cnt(10);
        count_high(20, v);
        chk("R7", v, 7);

        // partial pair: high byte only, no transfer
        tag = "R5";
        wr(0, 1);
        cyc(40);
        wait_cnt(10);
        count_high(20, v);
        chk("R5", v, 7);

        // complete pair, low byte last -> cv 7
        tag = "R4";
        wr(0, 0); wr(1, 7);
        wait_cnt(10); wait_cnt(0); wait_cnt(10);
        count_high(20, v);
        chk("R4", v, 13);

        // cv = mod -> 100%
        tag = "R7";
        wr(1, 10); wr(0, 0);
        wait_cnt(10); wait_cnt(0); wait_cnt(10);
        count_high(20, v);
        chk("R7", v, 20);

        // cv = mod-1 -> three low counts
        tag = "R8";
        wr(1, 9); wr(0, 0);
        wait_cnt(10); wait_cnt(0); wait_cnt(10);
        count_high(20, v);
        chk("R8", v, 17);

        // non-zero -> 0
        tag = "R10";
        wait_cnt(10);
        wr(0, 0); wr(1, 0);
        chk("R10", int'(pwm_out), 1);
        wait_cnt(10);
        cyc(2);
        chk("R10", int'(pwm_out), 0);
        count_high(20, v);
        chk("R10", v, 0);

        // 0 -> non-zero
        tag = "R9";
        wait_cnt(10);
        wr(0, 0); wr(1, 5);
        wait_cnt(0);
        chk("R9", int'(pwm_out), 0);
        wait_cnt(10); wait_cnt(0);
        chk("R9", int'(pwm_out), 1);

        // modulus change while running -> 6
        tag = "R12";
        wr(2, 0); wr(3, 6);
        cyc(40);
        max_cnt(30, v);
        chk("R12", v, 6);

        // debug-mode modulus write clears pairing
        tag = "R11";
        wr(2, 0);
        dbg_mode = 1'b1;
        wr(3, 3);
        dbg_mode = 1'b0;
        wr(3, 8);
        cyc(40);
        max_cnt(30, v);
        chk("R11", v, 6);
        wr(2, 0);
        cyc(40);
        max_cnt(30, v);
        chk("R11", v, 8);

        // free-running: mod 0, transfer at 0xFFFE -> 0xFFFF
        tag = "R6";
        clk_sel = 2'b00;
        wr(2, 0); wr(3, 0); wr(0, 8'h80); wr(1, 0);
        clk_sel = 2'b10;
        wr(0, 8'hFF); wr(1, 8'hFF);
        wait_cnt(16'hFFFE);
        chk("R6", int'(pwm_out), 0);
        @(negedge clk);
        chk("R6", int'(cnt_out), 16'hFFFF);
        chk("R6", int'(pwm_out), 1);
        cyc(4);
        finish_run();
    end

endmodule